// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the register front end of one DMA channel. A host reads and writes four 32-bit words through a simple word-access port. The four words are a control/status word, a transfer address word and two general storage words. The block has no data-moving engine of its own. It merges the attached peripheral's interrupt request with an enable bit to form a registered interrupt output. It drives two signals to the peripheral: a one-cycle reset pulse and a DMA-enable level. It also advances the address word each time the transfer engine reports a finished transfer of some byte count.

The control/status word has write-side special cases. Some of its bits are owned by hardware: the pending-interrupt bit, the "address loaded" flag and a fixed version code in the top bits. The drain bit changes in two ways a plain register would not. It is stored as zero when the host writes it as one, and it is stored as one when the host writes an all-zero word. The DMA-enable level is held by a two-state machine. In state LK_OFF the output is low, and a control/status write with the enable bit set takes the transition LK_OFF to LK_ON. In state LK_ON the output is high, and a control/status write with the enable bit clear takes the transition LK_ON to LK_OFF. Any other cycle leaves the state where it is.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control/status word reads 0xA0000000, the other three words read zero, and `irq_out`, `periph_rst` and `periph_dma_en` are low.
- R2: The word index is `bus_addr[3:2]`: 0 is control/status, 1 is address, 2 and 3 are storage words. Address bits above bit 3 are ignored, so the 16-byte window repeats.
- R3: Only accesses with `bus_size` equal to 2'b10 (a 32-bit word) are accepted. Any other size writes nothing, has no side effect and reads back zero.
- R4: On a control/status write, the bits under mask 0xFE000007 keep their stored value, and bits 31 and 29 (the version code 0xA0000000) are always set.
- R5: On a control/status write with bit 7 clear: if bit 6 (drain) is written as one, it is stored as zero; otherwise, if the whole written word is zero, bit 6 is stored as one.
- R6: A word write to the control/status word with bit 7 (peripheral reset) set makes `periph_rst` high for exactly the following cycle. Bit 7 is stored as written, and the drain handling of R5 is skipped.
- R7: `periph_dma_en` goes high the cycle after a control/status write with bit 9 set. It goes low the cycle after a control/status write with bit 9 clear. At all other times it holds.
- R8: A word write to the address word sets bit 26 (address loaded) of the control/status word. Host writes to the control/status word cannot clear bit 26.
- R9: Bit 0 of the control/status word (interrupt pending) takes the value of `periph_irq` sampled at each clock edge.
- R10: `irq_out` is registered. It is high in the cycle after an edge at which both the new pending bit and bit 4 (interrupt enable) are set.
- R11: When `xfer_done` is high, the address word increases by `xfer_len`. If a host write to the address word lands in the same cycle, the host value is taken and the increment is dropped.
- R12: Storage words 2 and 3 hold whatever was last written to them with a word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size; 2'b10 = 32-bit word |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| periph_irq | input | 1 | Interrupt request level from the peripheral |
| xfer_done | input | 1 | One transfer finished in this cycle |
| xfer_len | input | LEN_W | Byte count of the finished transfer |
| irq_out | output | 1 | Interrupt output |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |
| periph_dma_en | output | 1 | DMA-enable level to the peripheral |

## Verification
The hardest cases to reach are the ones where several sources act on one register edge. One is a host write to the address word in the same cycle as a transfer completion. Another is a control/status write that lands while the peripheral interrupt is changing. A third is a write that carries both the reset bit and the drain bit. The stimulus sets up each of these on purpose. It drives `xfer_done` in the same cycle as the address write, it writes control/status while `periph_irq` is held high, and it writes all ones. A behavioural reference model checks all three outputs on every clock, and reads check the register contents afterwards.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W = 2;
    localparam int NUM_WORDS = 1 << IDX_W;
    localparam int NUM_SPARE = NUM_WORDS - 2;
    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam logic [WORD_W-1:0] VERSION_CODE = 32'hA000_0000;
    localparam logic [WORD_W-1:0] HW_OWNED     = 32'hFE00_0007;

    localparam int PEND_B  = 0;
    localparam int IEN_B   = 4;
    localparam int DRAIN_B = 6;
    localparam int PRST_B  = 7;
    localparam int DIR_B   = 8;
    localparam int ENA_B   = 9;
    localparam int LOAD_B  = 26;

    typedef enum logic [IDX_W-1:0] {
        IDX_CSR  = 2'd0,
        IDX_ADDR = 2'd1,
        IDX_AUX0 = 2'd2,
        IDX_AUX1 = 2'd3
    } word_idx_e;

    typedef enum logic {
        LK_OFF = 1'b0,
        LK_ON  = 1'b1
    } link_state_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        word_idx_e         idx;
        logic [WORD_W-1:0] data;
    } host_op_t;
endpackage

// File: rtl/dmac_bus_dec.sv
module dmac_bus_dec
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output host_op_t          op
);
    logic size_ok;

    always_comb begin
        size_ok = (bus_size == SZ_WORD);
        op.wr   = bus_sel && bus_wr && size_ok;
        op.rd   = bus_sel && !bus_wr && size_ok;
        op.idx  = word_idx_e'(bus_addr[IDX_W+1:2]);
        op.data = bus_wdata;
    end
endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  host_op_t          op,
    input  logic              periph_irq,
    output logic [WORD_W-1:0] csr_q,
    output logic              csr_wr,
    output logic [WORD_W-1:0] csr_wval,
    output logic              irq_out
);
    logic [WORD_W-1:0] csr_d;
    logic              irq_q;

    function automatic logic [WORD_W-1:0] shape_write(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        r = v;
        if (!v[PRST_B]) begin
            if (v[DRAIN_B]) begin
                r[DRAIN_B] = 1'b0;
            end else if (v == '0) begin
                r[DRAIN_B] = 1'b1;
            end
        end
        return r;
    endfunction

    always_comb begin
        csr_wr   = op.wr && (op.idx == IDX_CSR);
        csr_wval = shape_write(op.data);
        csr_d    = csr_q;
        if (csr_wr) begin
            csr_d = (csr_q & HW_OWNED) | (csr_wval & ~HW_OWNED) | VERSION_CODE;
        end
        if (op.wr && (op.idx == IDX_ADDR)) begin
            csr_d[LOAD_B] = 1'b1;
        end
        csr_d[PEND_B] = periph_irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= VERSION_CODE;
            irq_q <= 1'b0;
        end else begin
            csr_q <= csr_d;
            irq_q <= csr_d[PEND_B] & csr_d[IEN_B];
        end
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/dmac_link_fsm.sv
module dmac_link_fsm
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [WORD_W-1:0] csr_wval,
    output logic              dma_en,
    output logic              rst_pulse
);
    link_state_e state_q, state_d;
    logic        pulse_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OFF: if (csr_wr && csr_wval[ENA_B])  state_d = LK_ON;
            LK_ON:  if (csr_wr && !csr_wval[ENA_B]) state_d = LK_OFF;
            default: state_d = LK_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= csr_wr && csr_wval[PRST_B];
        end
    end

    assign dma_en    = (state_q == LK_ON);
    assign rst_pulse = pulse_q;
endmodule

// File: rtl/dmac_addr.sv
module dmac_addr
    import dmac_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  host_op_t          op,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic [WORD_W-1:0] addr_q
);
    logic host_load;

    assign host_load = op.wr && (op.idx == IDX_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (host_load) begin
            addr_q <= op.data;
        end else if (xfer_done) begin
            addr_q <= addr_q + WORD_W'(xfer_len);
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              periph_irq,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              irq_out,
    output logic              periph_rst,
    output logic              periph_dma_en
);
    host_op_t          op;
    logic [WORD_W-1:0] csr_word;
    logic [WORD_W-1:0] addr_word;
    logic              csr_wr;
    logic [WORD_W-1:0] csr_wval;
    logic [WORD_W-1:0] words [NUM_WORDS];

    dmac_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .op        (op)
    );

    dmac_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .periph_irq (periph_irq),
        .csr_q      (csr_word),
        .csr_wr     (csr_wr),
        .csr_wval   (csr_wval),
        .irq_out    (irq_out)
    );

    dmac_link_fsm u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_wval  (csr_wval),
        .dma_en    (periph_dma_en),
        .rst_pulse (periph_rst)
    );

    dmac_addr #(.LEN_W(LEN_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .xfer_done (xfer_done),
        .xfer_len  (xfer_len),
        .addr_q    (addr_word)
    );

    assign words[IDX_CSR]  = csr_word;
    assign words[IDX_ADDR] = addr_word;

    for (genvar g = 0; g < NUM_SPARE; g++) begin : g_spare
        localparam int SLOT = g + 2;
        logic [WORD_W-1:0] store_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q <= '0;
            end else if (op.wr && (int'(op.idx) == SLOT)) begin
                store_q <= op.data;
            end
        end
        assign words[SLOT] = store_q;
    end

    assign bus_rdata = op.rd ? words[op.idx] : '0;
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              periph_irq,
    input logic              xfer_done,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              irq_out,
    input logic              periph_rst,
    input logic              periph_dma_en,
    input logic [31:0]       csr_q,
    input logic [31:0]       addr_q
);
    logic wword, csr_w, adr_w;
    assign wword = bus_sel && bus_wr && (bus_size == 2'b10);
    assign csr_w = wword && (bus_addr[3:2] == 2'd0);
    assign adr_w = wword && (bus_addr[3:2] == 2'd1);

    // R6
    rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst |-> $past(csr_w && bus_wdata[7]));

    // R7
    en_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_dma_en != $past(periph_dma_en)) |-> $past(csr_w));

    // R10
    irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(periph_irq));

    // R8
    loaded_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_w |=> csr_q[26]);

    // R8
    loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_q[26] |=> csr_q[26]);

    // R11
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !adr_w) |=> (addr_q == $past(addr_q) + 32'($past(xfer_len))));

    // R4
    version_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_w |=> (csr_q[31] && csr_q[29]));
endmodule

bind dma_chan_regs dmac_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_size      (bus_size),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .periph_irq    (periph_irq),
    .xfer_done     (xfer_done),
    .xfer_len      (xfer_len),
    .irq_out       (irq_out),
    .periph_rst    (periph_rst),
    .periph_dma_en (periph_dma_en),
    .csr_q         (csr_word),
    .addr_q        (addr_word)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 8;
    localparam logic [1:0] W = 2'b10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              b_sel = 1'b0, b_wr = 1'b0;
    logic [1:0]        b_size = W;
    logic [ADDR_W-1:0] b_addr = '0;
    logic [31:0]       b_wdata = '0;
    logic [31:0]       b_rdata;
    logic              p_irq = 1'b0, xd = 1'b0;
    logic [LEN_W-1:0]  xl = '0;
    logic              irq_out, periph_rst, periph_dma_en;

    int checks = 0, fails = 0, cyc = 0;

    logic [31:0] m_csr, m_addr, m_w2, m_w3;
    logic        m_irq = 1'b0, m_rst = 1'b0, m_en = 1'b0;

    always #5 clk = ~clk;

    dma_chan_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr),
        .bus_size(b_size), .bus_addr(b_addr), .bus_wdata(b_wdata),
        .bus_rdata(b_rdata), .periph_irq(p_irq), .xfer_done(xd),
        .xfer_len(xl), .irq_out(irq_out), .periph_rst(periph_rst),
        .periph_dma_en(periph_dma_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk) begin : model
        logic [31:0] v;
        logic        wok, adw;
        logic [1:0]  ix;
        cyc++;
        if (!rst_n) begin
            m_csr = 32'hA000_0000; m_addr = 0; m_w2 = 0; m_w3 = 0;
            m_irq = 0; m_rst = 0; m_en = 0;
        end else begin
            wok = b_sel && b_wr && (b_size == W);
            ix  = b_addr[3:2];
            adw = wok && (ix == 2'd1);
            m_rst = 0;
            if (wok) begin
                case (ix)
                    2'd0: begin
                        v = b_wdata;
                        if (v[7]) m_rst = 1;
                        else if (v[6]) v[6] = 0;
                        else if (v == 0) v = 32'h40;
                        m_csr = (m_csr & 32'hFE00_0007) | (v & ~32'hFE00_0007) | 32'hA000_0000;
                    end
                    2'd1: begin m_addr = b_wdata; m_csr[26] = 1; end
                    2'd2: m_w2 = b_wdata;
                    default: m_w3 = b_wdata;
                endcase
            end
            if (xd && !adw) m_addr = m_addr + 32'(xl);
            m_csr[0] = p_irq;
            m_en  = m_csr[9];
            m_irq = m_csr[0] & m_csr[4];
        end
    end

    // Per-cycle output comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 irq_out", 32'(irq_out), 32'(m_irq));
            chk("R6 periph_rst", 32'(periph_rst), 32'(m_rst));
            chk("R7 periph_dma_en", 32'(periph_dma_en), 32'(m_en));
        end
    end

    always @(posedge clk) begin
        if (cyc > 5000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        b_sel = 1; b_wr = 1; b_addr = a; b_size = sz; b_wdata = d;
        @(negedge clk);
        b_sel = 0; b_wr = 0; b_size = W;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        @(negedge clk);
        b_sel = 1; b_wr = 0; b_addr = a; b_size = sz;
        #1;
        chk(tag, b_rdata, exp);
        b_sel = 0; b_size = W;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq_out reset", 32'(irq_out), 0);
        chk("R1 periph_rst reset", 32'(periph_rst), 0);
        chk("R1 dma_en reset", 32'(periph_dma_en), 0);
        rst_n = 1;
        rd(8'h00, W, 32'hA000_0000, "R1 csr");
        rd(8'h04, W, 32'h0, "R1 addr");
        rd(8'h08, W, 32'h0, "R1 aux0");
        rd(8'h0C, W, 32'h0, "R1 aux1");

        wr(8'h00, W, 32'h0);
        rd(8'h00, W, 32'hA000_0040, "R5 zero write sets drain");
        wr(8'h00, W, 32'h40);
        rd(8'h00, W, 32'hA000_0000, "R5 drain write clears");

        wr(8'h00, W, 32'hFFFF_FFFF);
        rd(8'h00, W, 32'hA1FF_FFF8, "R4 R6 ro mask and reset skips drain");
        chk("R7 en high", 32'(periph_dma_en), 1);

        wr(8'h00, W, 32'h10);
        rd(8'h00, W, 32'hA000_0010, "R4 R7 ien only");
        chk("R7 en low", 32'(periph_dma_en), 0);

        @(negedge clk); p_irq = 1;
        idle(2);
        rd(8'h00, W, 32'hA000_0011, "R9 pending follows irq");
        chk("R10 irq out high", 32'(irq_out), 1);

        wr(8'h00, W, 32'h0);
        rd(8'h00, W, 32'hA000_0041, "R9 R5 write while irq high");
        chk("R10 irq out dropped", 32'(irq_out), 0);
        @(negedge clk); p_irq = 0;
        idle(2);

        wr(8'h14, W, 32'h0000_1000);
        rd(8'h44, W, 32'h0000_1000, "R2 aliased addr word");
        rd(8'h00, W, 32'hA400_0040, "R8 loaded set");
        wr(8'h00, W, 32'h0);
        rd(8'h00, W, 32'hA400_0040, "R8 loaded sticky");

        wr(8'h08, 2'b01, 32'h0000_DEAD);
        rd(8'h08, W, 32'h0, "R3 halfword write ignored");
        wr(8'h00, 2'b00, 32'h0000_0280);
        rd(8'h00, W, 32'hA400_0040, "R3 byte csr write ignored");
        rd(8'h04, 2'b01, 32'h0, "R3 halfword read zero");

        wr(8'h08, W, 32'h1234_5678);
        wr(8'hFC, W, 32'hCAFE_F00D);
        rd(8'h08, W, 32'h1234_5678, "R12 aux0");
        rd(8'h0C, W, 32'hCAFE_F00D, "R12 R2 aux1 via alias");

        @(negedge clk); xd = 1; xl = 8'd16;
        @(negedge clk); xl = 8'd255;
        @(negedge clk); xd = 0;
        rd(8'h04, W, 32'h0000_110F, "R11 two transfers");

        @(negedge clk);
        b_sel = 1; b_wr = 1; b_addr = 8'h04; b_size = W; b_wdata = 32'h2000;
        xd = 1; xl = 8'd8;
        @(negedge clk);
        b_sel = 0; b_wr = 0; xd = 0;
        rd(8'h04, W, 32'h0000_2000, "R11 host write wins");

        wr(8'h00, W, 32'h200);
        chk("R7 en rise", 32'(periph_dma_en), 1);
        wr(8'h00, W, 32'h280);
        chk("R7 en holds over reset write", 32'(periph_dma_en), 1);
        rd(8'h00, W, 32'hA400_0280, "R6 reset bit stored");
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule